// File: doc/BRIEF.md
# Frame Parity Error Monitor

This block watches a byte-wide SONET/SDH stream whose frame boundary is already known, and measures section parity errors. It keeps a running even parity (bitwise XOR) of every accepted byte of a frame. When the next frame begins, that value becomes the reference for the parity byte carried by that next frame. When the parity-byte strobe arrives, the received byte is compared bit by bit with the reference. The number of disagreeing bits, from 0 to 8, is added to a saturating error accumulator.

A free-running cycle timer divides time into measurement windows whose length the host programs. When a window closes, the accumulated total is copied into a holding register that the host can read, and the accumulator starts again from zero in the same cycle. An interrupt flag is raised at the same time and stays set until the host clears it. A loss-of-frame input discards the parity history, so that no false error is counted while framing recovers.

Top module: `frame_parity_monitor`

## Requirements
- R1: The frame parity is the XOR of every byte accepted with `data_en` high, from the byte carrying `sof` up to the last accepted byte before the next `sof`. This includes the parity byte itself. Bytes presented with `data_en` low have no effect.
- R2: On the accepted byte marked by `b1_pos`, when checking is armed, the received byte is compared with the parity of the previous frame. Each bit position that differs adds one to the accumulator, so one frame adds between 0 and 8. The `b1_pos` strobe must come on a later byte than the frame's `sof`.
- R3: After reset, or after any cycle with `frame_lost` high, no parity byte is checked until two frame starts have been accepted. The first frame seen only seeds the reference parity.
- R4: A window closes in the first cycle in which the number of cycles elapsed since reset or since the last close, plus one, is at least `period_len`. With `period_len` = 10 after reset, the close takes effect at the tenth rising edge. The values 0 and 1 both give one-cycle windows.
- R5: When a window closes, `err_total` takes the accumulator plus any errors found in that same cycle, and the accumulator restarts from zero. No error is lost or counted twice.
- R6: The accumulator and `err_total` saturate at 2^CNT_W-1 and never wrap.
- R7: `irq` is set by every window close and stays set until a cycle with `irq_clear` high and no close. A close in the same cycle as a clear leaves `irq` set.
- R8: After reset, `err_total` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 8 | Aligned stream byte |
| data_en | input | 1 | Byte on `data_in` is valid this cycle |
| sof | input | 1 | Byte is the first byte of a frame |
| b1_pos | input | 1 | Byte is the frame's parity byte |
| frame_lost | input | 1 | Framing lost; drop parity history |
| period_len | input | PERIOD_W | Window length in clock cycles |
| irq_clear | input | 1 | Host clear of the interrupt flag |
| err_total | output | CNT_W | Error count of the last closed window |
| irq | output | 1 | Window-closed interrupt flag |

## Verification
The stream is driven with correct parity bytes, which must add nothing. It is then driven with single-bit errors at the lowest and highest bit and with an all-bits error, which separates a per-bit count from a per-frame count. Frames with idle gaps carrying junk data show whether bytes with `data_en` low are left out of the parity. Parity bytes with deliberate errors placed right after reset and right after loss of frame show whether the history is dropped. An error that arrives in the very cycle a window closes, a long run of 8-error frames, and clear/close collisions probe the window edge, saturation and flag behaviour.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  // Number of bit positions where two bytes disagree (0..8)
  function automatic logic [3:0] bit_mismatch(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) begin
      n = n + {3'd0, a[i] ^ b[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/fpm_bip_calc.sv
module fpm_bip_calc
  import fpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_in,
  input  logic       data_en,
  input  logic       sof,
  input  logic       b1_pos,
  input  logic       frame_lost,
  output logic [3:0] err_bits
);

  logic [7:0] run_par;
  logic [7:0] ref_par;
  logic       frame_seen;
  logic       ref_valid;
  logic       frame_start;
  logic       check_hit;

  assign frame_start = sof && data_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_par    <= 8'd0;
      ref_par    <= 8'd0;
      frame_seen <= 1'b0;
      ref_valid  <= 1'b0;
    end else if (frame_lost) begin
      run_par    <= 8'd0;
      frame_seen <= 1'b0;
      ref_valid  <= 1'b0;
    end else if (frame_start) begin
      run_par    <= data_in;
      frame_seen <= 1'b1;
      if (frame_seen) begin
        ref_par   <= run_par;
        ref_valid <= 1'b1;
      end
    end else if (data_en) begin
      run_par <= run_par ^ data_in;
    end
  end

  assign check_hit = data_en && b1_pos && !sof && ref_valid && !frame_lost;
  assign err_bits  = check_hit ? bit_mismatch(ref_par, data_in) : 4'd0;

  // R3: loss of frame disarms checking
  a_r3_lost_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |=> !ref_valid);

  // R3: a second frame start arms checking
  a_r3_arm_second_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_seen && !frame_lost) |=> ref_valid);

  // R2: errors only appear on a parity byte
  a_r2_err_only_on_b1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bits != 4'd0) |-> (b1_pos && data_en));

endmodule

// File: rtl/fpm_period_timer.sv
module fpm_period_timer #(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_len,
  output logic                win_close
);

  logic [PERIOD_W-1:0] elapsed;
  logic [PERIOD_W:0]   elapsed_next;

  assign elapsed_next = {1'b0, elapsed} + {{PERIOD_W{1'b0}}, 1'b1};
  assign win_close    = elapsed_next >= {1'b0, period_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (win_close) begin
      elapsed <= '0;
    end else begin
      elapsed <= elapsed_next[PERIOD_W-1:0];
    end
  end

  // R4: a close restarts the elapsed count
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (elapsed == '0));

endmodule

// File: rtl/fpm_err_accum.sv
module fpm_err_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       add_bits,
  input  logic             win_close,
  output logic [CNT_W-1:0] total
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] sum;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [3:0] b);
    logic [CNT_W:0] wide;
    wide = {1'b0, a} + {{(CNT_W-3){1'b0}}, b};
    return wide[CNT_W] ? CNT_MAX : wide[CNT_W-1:0];
  endfunction

  assign sum = sat_add(acc, add_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      total <= '0;
    end else if (win_close) begin
      acc   <= '0;
      total <= sum;
    end else begin
      acc   <= sum;
    end
  end

  // R5: accumulator restarts at a close
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (acc == '0));

  // R6: accumulator never decreases inside a window
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> (acc >= $past(acc)));

  // R6: saturated value holds
  a_r6_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_close && acc == CNT_MAX) |=> (acc == CNT_MAX));

  // R5: held total changes only at a close
  a_r5_total_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> $stable(total));

endmodule

// File: rtl/frame_parity_monitor.sv
module frame_parity_monitor #(
  parameter int CNT_W    = 16,
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          data_in,
  input  logic                data_en,
  input  logic                sof,
  input  logic                b1_pos,
  input  logic                frame_lost,
  input  logic [PERIOD_W-1:0] period_len,
  input  logic                irq_clear,
  output logic [CNT_W-1:0]    err_total,
  output logic                irq
);

  logic [3:0] frame_err_bits;
  logic       win_close;

  fpm_bip_calc u_bip (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_in    (data_in),
    .data_en    (data_en),
    .sof        (sof),
    .b1_pos     (b1_pos),
    .frame_lost (frame_lost),
    .err_bits   (frame_err_bits)
  );

  fpm_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_len (period_len),
    .win_close  (win_close)
  );

  fpm_err_accum #(.CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_bits  (frame_err_bits),
    .win_close (win_close),
    .total     (err_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (win_close) begin
      irq <= 1'b1;
    end else if (irq_clear) begin
      irq <= 1'b0;
    end
  end

  // R7: a close always raises the flag
  a_r7_set_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> irq);

  // R7: the flag holds without a clear
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);

  // R7: a clear without a close drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !win_close) |=> !irq);

endmodule

// File: tb/test_frame_parity_monitor.sv
module test_frame_parity_monitor;

  localparam int CNT_W    = 8;
  localparam int PERIOD_W = 16;
  localparam int CMAX     = (1 << CNT_W) - 1;
  localparam int LONG_WIN = 1000;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [7:0]          data_in;
  logic                data_en;
  logic                sof;
  logic                b1_pos;
  logic                frame_lost;
  logic [PERIOD_W-1:0] period_len;
  logic                irq_clear;
  logic [CNT_W-1:0]    err_total;
  logic                irq;

  int checks = 0;
  int errors = 0;
  int model_acc = 0;
  logic [7:0] last_par = 8'd0;

  always #10 clk = ~clk;

  frame_parity_monitor #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W)) i_frame_parity_monitor (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_en(data_en), .sof(sof),
    .b1_pos(b1_pos), .frame_lost(frame_lost), .period_len(period_len),
    .irq_clear(irq_clear), .err_total(err_total), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic en, input logic s, input logic b);
    data_in = d; data_en = en; sof = s; b1_pos = b;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  // Six-byte frame: byte 0 starts it, byte 1 is the parity byte
  task automatic send_frame(input logic [7:0] b1val, input logic [7:0] seed,
                            input bit gaps, input bit close_on_b1);
    logic [7:0] par;
    logic [7:0] d;
    par = 8'd0;
    for (int k = 0; k < 6; k++) begin
      d = (k == 0) ? seed : (k == 1) ? b1val : ((seed ^ (8'h35 * k[7:0])) + k[7:0]);
      par = par ^ d;
      if (k == 1 && close_on_b1) period_len = 1;
      put(d, 1'b1, k == 0, k == 1);
      if (k == 1 && close_on_b1) period_len = LONG_WIN;
      if (gaps) put(8'hA5 ^ d, 1'b0, 1'b0, 1'b0);
    end
    last_par = par;
  endtask

  // Frame whose parity byte carries the given error mask
  task automatic err_frame(input logic [7:0] mask, input logic [7:0] seed, input bit counted);
    send_frame(last_par ^ mask, seed, 1'b0, 1'b0);
    if (counted) model_acc += $countones(mask);
  endtask

  task automatic close_window(input string req);
    period_len = 1;
    idle(1);
    period_len = LONG_WIN;
    check(req, int'(err_total), (model_acc > CMAX) ? CMAX : model_acc);
    check("R7 irq set on close", int'(irq), 1);
    model_acc = 0;
    irq_clear = 1'b1;
    idle(1);
    irq_clear = 1'b0;
    check("R7 irq cleared", int'(irq), 0);
  endtask

  task automatic do_reset(input int plen);
    rst_n = 1'b0; data_in = 0; data_en = 0; sof = 0; b1_pos = 0;
    frame_lost = 0; irq_clear = 0; period_len = plen[PERIOD_W-1:0];
    model_acc = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(LONG_WIN);
    check("R8 err_total after reset", int'(err_total), 0);
    check("R8 irq after reset", int'(irq), 0);
  endtask

  task automatic t_first_frame_and_clean();
    err_frame(8'hFF, 8'h11, 1'b0);   // R3: first frame unchecked
    err_frame(8'h00, 8'h22, 1'b1);   // R2: correct parity adds nothing
    err_frame(8'h00, 8'h33, 1'b1);
    idle(2);
    close_window("R3 first frame after reset unchecked");
  endtask

  task automatic t_bit_errors();
    err_frame(8'h01, 8'h44, 1'b1);
    err_frame(8'h80, 8'h55, 1'b1);
    err_frame(8'hFF, 8'h66, 1'b1);
    idle(1);
    check("R5 accumulating before close", int'(err_total), 0);
    close_window("R2 per-bit count 1+1+8");
  endtask

  task automatic t_gaps();
    send_frame(last_par, 8'h77, 1'b1, 1'b0);
    err_frame(8'h00, 8'h88, 1'b1);
    err_frame(8'h02, 8'h99, 1'b1);
    idle(1);
    close_window("R1 idle bytes excluded from parity");
  endtask

  task automatic t_close_on_error();
    send_frame(last_par ^ 8'h0F, 8'h12, 1'b0, 1'b1);
    check("R5 error in closing cycle latched", int'(err_total), 4);
    check("R7 irq from close", int'(irq), 1);
    irq_clear = 1'b1; idle(1); irq_clear = 1'b0;
    model_acc = 0;
    err_frame(8'h03, 8'h23, 1'b1);
    idle(1);
    close_window("R5 accumulator restarted at close");
  endtask

  task automatic t_frame_lost();
    frame_lost = 1'b1; idle(1); frame_lost = 1'b0;
    err_frame(8'hFF, 8'h34, 1'b0);   // unchecked after loss
    err_frame(8'h10, 8'h45, 1'b1);
    idle(1);
    close_window("R3 first frame after loss unchecked");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 40; i++) err_frame(8'hFF, 8'(i * 7 + 1), 1'b1);
    idle(1);
    check("R6 model above max", int'(model_acc > CMAX), 1);
    close_window("R6 saturates at maximum");
  endtask

  task automatic t_irq_collision();
    period_len = 1; irq_clear = 1'b1;
    idle(1);
    period_len = LONG_WIN; irq_clear = 1'b0;
    check("R7 close beats clear", int'(irq), 1);
    idle(5);
    check("R7 irq held", int'(irq), 1);
    irq_clear = 1'b1; idle(1); irq_clear = 1'b0;
    check("R7 irq cleared by host", int'(irq), 0);
  endtask

  task automatic t_period();
    do_reset(10);
    idle(9);
    check("R4 no close before tenth edge", int'(irq), 0);
    idle(1);
    check("R4 close at tenth edge", int'(irq), 1);
  endtask

  initial begin
    t_reset_state();
    t_first_frame_and_clean();
    t_bit_errors();
    t_gaps();
    t_close_on_error();
    t_frame_lost();
    t_saturate();
    t_irq_collision();
    t_period();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule